// File: doc/BRIEF.md
# Pipeline Bypass and Hazard Controller

This block holds the combinational control for a scalar, in-order, five-stage pipeline. It looks at the register fields, the operation class and the valid bit of the instructions in the fetch/decode, decode/execute, execute/memory and memory/writeback latches. From these it chooses where each execute-stage operand comes from. It also chooses whether the store data entering memory is taken from the writeback stage.

It detects the one case that forwarding cannot cover: a value loaded from memory and needed by the very next instruction. In that case it freezes the front of the pipe and inserts one bubble.

When execute resolves a branch as taken, it squashes the two younger instructions. A flush overrides any stall in the same cycle.

The datapath uses the select codes directly as mux controls. The stall, bubble and flush outputs act as write enables and clear strobes on the pipeline latches.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: `alu_a_sel` is 0 (execute/memory result) when the D/X source-1 field matches a producing X/M instruction. Otherwise it is 1 (memory/writeback result) when that field matches a producing M/W instruction. Otherwise it is 2 (register file). When both stages match, the X/M result wins.
- R2: `alu_b_sel` follows the R1 rule with the D/X source-2 field, independently of `alu_a_sel`.
- R3: No forward or stall match ever involves register 0, an invalid latch, or a producer whose operation class writes no register. Classes are NOP=0, ALU=1, LOAD=2, STORE=3, BRANCH=4, and only ALU and LOAD write a register. An invalid D/X gives select 2 on both inputs.
- R4: `st_data_sel` is 1 only when the valid X/M instruction is a STORE and its source-2 (data) field matches a producing M/W destination. Otherwise it is 0.
- R5: A load-use stall is raised when D/X holds a valid LOAD with a nonzero destination, and a valid non-NOP F/D instruction reads that destination as source 1.
- R6: A match on F/D source 2 raises the stall only when the F/D instruction is not a STORE. An invalid or NOP F/D instruction never causes a stall.
- R7: During a stall, `stall_fd` and `bubble_dx` are both 1 and both flush outputs are 0. Otherwise `stall_fd` and `bubble_dx` are 0.
- R8: When `br_taken` is 1, `flush_fd` and `flush_dx` are 1 and `stall_fd` and `bubble_dx` are 0. When `br_taken` is 0, both flushes are 0.
- R9: In a running pipe, a load followed at once by a dependent instruction costs exactly one bubble. The consumer then reads the loaded value with select 1. Instructions on the wrong path of a taken branch never reach X/M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fd_valid | input | 1 | F/D latch holds a real instruction |
| fd_op | input | 3 | F/D operation class |
| fd_rs1 | input | 5 | F/D source-1 register |
| fd_rs2 | input | 5 | F/D source-2 register |
| dx_valid | input | 1 | D/X latch holds a real instruction |
| dx_op | input | 3 | D/X operation class |
| dx_rs1 | input | 5 | D/X source-1 register |
| dx_rs2 | input | 5 | D/X source-2 register |
| dx_rd | input | 5 | D/X destination register |
| xm_valid | input | 1 | X/M latch holds a real instruction |
| xm_op | input | 3 | X/M operation class |
| xm_rs2 | input | 5 | X/M source-2 (store data) register |
| xm_rd | input | 5 | X/M destination register |
| mw_valid | input | 1 | M/W latch holds a real instruction |
| mw_op | input | 3 | M/W operation class |
| mw_rd | input | 5 | M/W destination register |
| br_taken | input | 1 | Branch in execute resolved taken |
| alu_a_sel | output | 2 | ALU input A source select |
| alu_b_sel | output | 2 | ALU input B source select |
| st_data_sel | output | 1 | Store data from writeback when 1 |
| stall_fd | output | 1 | Hold PC and F/D |
| bubble_dx | output | 1 | Write a nop into D/X |
| flush_fd | output | 1 | Write a nop into F/D |
| flush_dx | output | 1 | Write a nop into D/X |

## Verification
The block holds no state, so any fault shows on the outputs in the same cycle that the latch contents present the case. A wrong priority or a missing register-0 guard shows up as a select code that differs from the bench model right away. A broken store exception or a broken flush priority shows up as an extra or missing bubble. In the stub pipeline, that error then shifts every later instruction by a cycle and shows up again in the following comparisons. A wrong-path instruction reaching X/M within two cycles of a missed flush is counted at the end of the run.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;

  localparam int unsigned OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP    = 3'd0,
    OPC_ALU    = 3'd1,
    OPC_LOAD   = 3'd2,
    OPC_STORE  = 3'd3,
    OPC_BRANCH = 3'd4
  } opc_e;

  typedef enum logic [1:0] {
    SRC_XM = 2'd0,
    SRC_MW = 2'd1,
    SRC_RF = 2'd2
  } fwd_src_e;

  // Only these classes leave a result in the register file.
  function automatic logic writes_reg(opc_e op);
    return (op == OPC_ALU) || (op == OPC_LOAD);
  endfunction

endpackage

// File: rtl/pipe_fwd_select.sv
module pipe_fwd_select
  import pipe_hazard_pkg::*;
#(
  parameter int unsigned RIDX_W = 5
) (
  input  logic              use_vld,
  input  logic [RIDX_W-1:0] src,
  input  logic              xm_vld,
  input  opc_e              xm_op,
  input  logic [RIDX_W-1:0] xm_rd,
  input  logic              mw_vld,
  input  opc_e              mw_op,
  input  logic [RIDX_W-1:0] mw_rd,
  output fwd_src_e          sel
);

  function automatic logic producer_hit(logic vld, opc_e op,
                                        logic [RIDX_W-1:0] rd,
                                        logic [RIDX_W-1:0] s);
    return vld && writes_reg(op) && (rd != '0) && (rd == s);
  endfunction

  logic xm_hit;
  logic mw_hit;

  assign xm_hit = use_vld && producer_hit(xm_vld, xm_op, xm_rd, src);
  assign mw_hit = use_vld && producer_hit(mw_vld, mw_op, mw_rd, src);

  always_comb begin
    if (xm_hit)      sel = SRC_XM;
    else if (mw_hit) sel = SRC_MW;
    else             sel = SRC_RF;
  end

  always_comb begin
    if (xm_hit) AST_XM_WINS: assert (sel == SRC_XM); // R1
    if (src == '0) AST_R0_NO_FWD: assert (sel == SRC_RF); // R3
    if (!use_vld) AST_IDLE_USES_RF: assert (sel == SRC_RF); // R3
  end

endmodule

// File: rtl/pipe_wm_store_fwd.sv
module pipe_wm_store_fwd
  import pipe_hazard_pkg::*;
#(
  parameter int unsigned RIDX_W = 5
) (
  input  logic              xm_vld,
  input  opc_e              xm_op,
  input  logic [RIDX_W-1:0] xm_rs2,
  input  logic              mw_vld,
  input  opc_e              mw_op,
  input  logic [RIDX_W-1:0] mw_rd,
  output logic              st_fwd
);

  logic store_in_mem;
  logic data_hit;

  assign store_in_mem = xm_vld && (xm_op == OPC_STORE);
  assign data_hit     = mw_vld && writes_reg(mw_op) && (mw_rd != '0) && (mw_rd == xm_rs2);
  assign st_fwd       = store_in_mem && data_hit;

  always_comb begin
    if (st_fwd) AST_WM_ONLY_STORE: assert (xm_op == OPC_STORE && xm_rs2 != '0); // R4
  end

endmodule

// File: rtl/pipe_load_use.sv
module pipe_load_use
  import pipe_hazard_pkg::*;
#(
  parameter int unsigned RIDX_W = 5
) (
  input  logic              fd_vld,
  input  opc_e              fd_op,
  input  logic [RIDX_W-1:0] fd_rs1,
  input  logic [RIDX_W-1:0] fd_rs2,
  input  logic              dx_vld,
  input  opc_e              dx_op,
  input  logic [RIDX_W-1:0] dx_rd,
  output logic              hazard
);

  logic load_in_ex;
  logic fd_reads;
  logic rs1_dep;
  logic rs2_dep;

  assign load_in_ex = dx_vld && (dx_op == OPC_LOAD) && (dx_rd != '0);
  assign fd_reads   = fd_vld && (fd_op != OPC_NOP);
  assign rs1_dep    = (fd_rs1 == dx_rd);
  // Store data is picked up late through the writeback-to-memory path.
  assign rs2_dep    = (fd_rs2 == dx_rd) && (fd_op != OPC_STORE);
  assign hazard     = load_in_ex && fd_reads && (rs1_dep || rs2_dep);

  always_comb begin
    if (hazard) AST_STALL_NEEDS_LOAD: assert (dx_vld && dx_op == OPC_LOAD); // R5
    if (hazard && fd_op == OPC_STORE) AST_STORE_STALL_RS1: assert (fd_rs1 == dx_rd); // R6
    if (!fd_vld) AST_EMPTY_FD_NO_STALL: assert (!hazard); // R6
  end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hazard_pkg::*;
#(
  parameter int unsigned RIDX_W = 5
) (
  input  logic              fd_valid,
  input  logic [OPC_W-1:0]  fd_op,
  input  logic [RIDX_W-1:0] fd_rs1,
  input  logic [RIDX_W-1:0] fd_rs2,
  input  logic              dx_valid,
  input  logic [OPC_W-1:0]  dx_op,
  input  logic [RIDX_W-1:0] dx_rs1,
  input  logic [RIDX_W-1:0] dx_rs2,
  input  logic [RIDX_W-1:0] dx_rd,
  input  logic              xm_valid,
  input  logic [OPC_W-1:0]  xm_op,
  input  logic [RIDX_W-1:0] xm_rs2,
  input  logic [RIDX_W-1:0] xm_rd,
  input  logic              mw_valid,
  input  logic [OPC_W-1:0]  mw_op,
  input  logic [RIDX_W-1:0] mw_rd,
  input  logic              br_taken,
  output logic [1:0]        alu_a_sel,
  output logic [1:0]        alu_b_sel,
  output logic              st_data_sel,
  output logic              stall_fd,
  output logic              bubble_dx,
  output logic              flush_fd,
  output logic              flush_dx
);

  localparam int unsigned N_ALU_IN = 2;

  opc_e fd_opc, dx_opc, xm_opc, mw_opc;
  assign fd_opc = opc_e'(fd_op);
  assign dx_opc = opc_e'(dx_op);
  assign xm_opc = opc_e'(xm_op);
  assign mw_opc = opc_e'(mw_op);

  logic [RIDX_W-1:0] ex_src [N_ALU_IN];
  fwd_src_e          ex_sel [N_ALU_IN];

  assign ex_src[0] = dx_rs1;
  assign ex_src[1] = dx_rs2;

  for (genvar g = 0; g < N_ALU_IN; g++) begin : g_alu_in
    pipe_fwd_select #(.RIDX_W(RIDX_W)) u_sel (
      .use_vld (dx_valid),
      .src     (ex_src[g]),
      .xm_vld  (xm_valid),
      .xm_op   (xm_opc),
      .xm_rd   (xm_rd),
      .mw_vld  (mw_valid),
      .mw_op   (mw_opc),
      .mw_rd   (mw_rd),
      .sel     (ex_sel[g])
    );
  end

  assign alu_a_sel = ex_sel[0];
  assign alu_b_sel = ex_sel[1];

  pipe_wm_store_fwd #(.RIDX_W(RIDX_W)) u_wm (
    .xm_vld (xm_valid),
    .xm_op  (xm_opc),
    .xm_rs2 (xm_rs2),
    .mw_vld (mw_valid),
    .mw_op  (mw_opc),
    .mw_rd  (mw_rd),
    .st_fwd (st_data_sel)
  );

  logic lu_hazard;

  pipe_load_use #(.RIDX_W(RIDX_W)) u_lu (
    .fd_vld (fd_valid),
    .fd_op  (fd_opc),
    .fd_rs1 (fd_rs1),
    .fd_rs2 (fd_rs2),
    .dx_vld (dx_valid),
    .dx_op  (dx_opc),
    .dx_rd  (dx_rd),
    .hazard (lu_hazard)
  );

  // A taken branch squashes the stalled instruction, so the flush wins.
  logic hold_front;
  assign hold_front = lu_hazard && !br_taken;
  assign stall_fd   = hold_front;
  assign bubble_dx  = hold_front;
  assign flush_fd   = br_taken;
  assign flush_dx   = br_taken;

  always_comb begin
    if (lu_hazard && !br_taken) AST_STALL_HOLDS_FRONT: assert (stall_fd && bubble_dx && !flush_fd && !flush_dx); // R7
    if (br_taken) AST_FLUSH_OVER_STALL: assert (!stall_fd && !bubble_dx && flush_fd && flush_dx); // R8
  end

endmodule

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;

  typedef struct {
    bit v;
    int op;
    int rs1;
    int rs2;
    int rd;
    bit tk;
    int tgt;
    int id;
  } ins_t;

  localparam int NOP = 0, ALU = 1, LOAD = 2, STORE = 3, BRANCH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  ins_t fd_l, dx_l, xm_l, mw_l;
  logic br_in;

  logic [1:0] alu_a_sel, alu_b_sel;
  logic st_data_sel, stall_fd, bubble_dx, flush_fd, flush_dx;

  pipe_hazard_ctrl uut (
    .fd_valid (fd_l.v), .fd_op (fd_l.op[2:0]), .fd_rs1 (fd_l.rs1[4:0]), .fd_rs2 (fd_l.rs2[4:0]),
    .dx_valid (dx_l.v), .dx_op (dx_l.op[2:0]), .dx_rs1 (dx_l.rs1[4:0]), .dx_rs2 (dx_l.rs2[4:0]),
    .dx_rd (dx_l.rd[4:0]),
    .xm_valid (xm_l.v), .xm_op (xm_l.op[2:0]), .xm_rs2 (xm_l.rs2[4:0]), .xm_rd (xm_l.rd[4:0]),
    .mw_valid (mw_l.v), .mw_op (mw_l.op[2:0]), .mw_rd (mw_l.rd[4:0]),
    .br_taken (br_in),
    .alu_a_sel (alu_a_sel), .alu_b_sel (alu_b_sel), .st_data_sel (st_data_sel),
    .stall_fd (stall_fd), .bubble_dx (bubble_dx), .flush_fd (flush_fd), .flush_dx (flush_dx)
  );

  function automatic ins_t mk(int op, int rd, int rs1, int rs2, int id);
    ins_t t;
    t.v = 1'b1; t.op = op; t.rd = rd; t.rs1 = rs1; t.rs2 = rs2;
    t.tk = 1'b0; t.tgt = 0; t.id = id;
    return t;
  endfunction

  function automatic ins_t bubble();
    ins_t t;
    t.v = 1'b0; t.op = NOP; t.rd = 0; t.rs1 = 0; t.rs2 = 0;
    t.tk = 1'b0; t.tgt = 0; t.id = -1;
    return t;
  endfunction

  // Reference model: a producer counts only if valid, writing, and not r0.
  function automatic bit gives(ins_t p, int r);
    if (!p.v || r == 0) return 1'b0;
    if (p.op != ALU && p.op != LOAD) return 1'b0;
    return p.rd == r;
  endfunction

  function automatic int want_sel(int r);
    if (!dx_l.v) return 2;
    if (gives(xm_l, r)) return 0;
    if (gives(mw_l, r)) return 1;
    return 2;
  endfunction

  function automatic bit want_st();
    return xm_l.v && xm_l.op == STORE && gives(mw_l, xm_l.rs2);
  endfunction

  function automatic bit want_hz();
    bit dep;
    if (!(dx_l.v && dx_l.op == LOAD && dx_l.rd != 0)) return 1'b0;
    if (!fd_l.v || fd_l.op == NOP) return 1'b0;
    dep = (fd_l.rs1 == dx_l.rd);
    if (fd_l.op != STORE && fd_l.rs2 == dx_l.rd) dep = 1'b1;
    return dep && !br_in;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    fd_l = bubble(); dx_l = bubble(); xm_l = bubble(); mw_l = bubble();
    br_in = 1'b0;
  endtask

  task automatic compare_all();
    chk("R1 alu_a_sel", int'(alu_a_sel), want_sel(dx_l.rs1));
    chk("R2 alu_b_sel", int'(alu_b_sel), want_sel(dx_l.rs2));
    chk("R4 st_data_sel", int'(st_data_sel), int'(want_st()));
    chk("R5 stall_fd", int'(stall_fd), int'(want_hz()));
    chk("R7 bubble_dx", int'(bubble_dx), int'(want_hz()));
    chk("R8 flush_fd", int'(flush_fd), int'(br_in));
    chk("R8 flush_dx", int'(flush_dx), int'(br_in));
  endtask

  ins_t prog [12];

  initial begin
    int pc;
    int bubbles;
    int wrong_path;
    bit h, bt;
    clear_all();

    @(negedge clk);
    // Empty pipe state
    chk("R3 idle alu_a_sel", int'(alu_a_sel), 2);
    chk("R3 idle alu_b_sel", int'(alu_b_sel), 2);
    chk("R7 idle stall_fd", int'(stall_fd), 0);
    chk("R8 idle flush_fd", int'(flush_fd), 0);
    chk("R4 idle st_data_sel", int'(st_data_sel), 0);

    // R1 priority
    dx_l = mk(ALU, 9, 5, 6, 0); xm_l = mk(ALU, 5, 1, 1, 1); mw_l = mk(LOAD, 5, 1, 1, 2);
    @(negedge clk); chk("R1 both match picks X/M", int'(alu_a_sel), 0);
    xm_l = mk(ALU, 7, 1, 1, 1);
    @(negedge clk); chk("R1 only M/W match", int'(alu_a_sel), 1);
    mw_l = mk(ALU, 8, 1, 1, 2);
    @(negedge clk); chk("R1 no match uses regfile", int'(alu_a_sel), 2);

    // R2 independent B select
    xm_l = mk(ALU, 6, 1, 1, 1);
    @(negedge clk);
    chk("R2 B forwards X/M", int'(alu_b_sel), 0);
    chk("R2 A unaffected", int'(alu_a_sel), 2);

    // R3 exclusions
    dx_l = mk(ALU, 9, 0, 4, 0); xm_l = mk(ALU, 0, 1, 1, 1); mw_l = mk(ALU, 0, 1, 1, 2);
    @(negedge clk); chk("R3 r0 never forwarded", int'(alu_a_sel), 2);
    xm_l = mk(STORE, 4, 1, 1, 1);
    @(negedge clk); chk("R3 store is no producer", int'(alu_b_sel), 2);
    xm_l = mk(ALU, 4, 1, 1, 1); xm_l.v = 1'b0;
    @(negedge clk); chk("R3 invalid X/M ignored", int'(alu_b_sel), 2);
    xm_l.v = 1'b1; dx_l.v = 1'b0;
    @(negedge clk); chk("R3 invalid D/X uses regfile", int'(alu_b_sel), 2);
    clear_all();
    dx_l = mk(LOAD, 0, 1, 0, 0); fd_l = mk(ALU, 5, 0, 0, 1);
    @(negedge clk); chk("R3 load to r0 no stall", int'(stall_fd), 0);

    // R4 writeback to store data
    clear_all();
    xm_l = mk(STORE, 0, 2, 7, 0); mw_l = mk(LOAD, 7, 1, 1, 1);
    @(negedge clk); chk("R4 store data forwarded", int'(st_data_sel), 1);
    mw_l = mk(STORE, 7, 1, 1, 1);
    @(negedge clk); chk("R4 store producer ignored", int'(st_data_sel), 0);
    xm_l = mk(ALU, 3, 2, 7, 0); mw_l = mk(LOAD, 7, 1, 1, 1);
    @(negedge clk); chk("R4 non-store in X/M", int'(st_data_sel), 0);

    // R5/R6/R7 load-use stall
    clear_all();
    dx_l = mk(LOAD, 3, 1, 0, 0); fd_l = mk(ALU, 4, 3, 2, 1);
    @(negedge clk);
    chk("R5 rs1 dependence stalls", int'(stall_fd), 1);
    chk("R7 bubble with stall", int'(bubble_dx), 1);
    chk("R7 no flush in stall", int'(flush_dx), 0);
    fd_l = mk(STORE, 0, 1, 3, 1);
    @(negedge clk); chk("R6 store data dependence no stall", int'(stall_fd), 0);
    fd_l = mk(ALU, 4, 1, 3, 1);
    @(negedge clk); chk("R6 rs2 dependence stalls", int'(stall_fd), 1);
    fd_l.v = 1'b0;
    @(negedge clk); chk("R6 invalid F/D no stall", int'(stall_fd), 0);
    fd_l = mk(NOP, 0, 3, 3, 1);
    @(negedge clk); chk("R6 nop F/D no stall", int'(bubble_dx), 0);
    fd_l = mk(ALU, 4, 3, 2, 1); dx_l = mk(ALU, 3, 1, 0, 0);
    @(negedge clk); chk("R5 ALU producer no stall", int'(stall_fd), 0);

    // R8 flush priority
    dx_l = mk(LOAD, 3, 1, 0, 0); br_in = 1'b1;
    @(negedge clk);
    chk("R8 flush suppresses stall", int'(stall_fd), 0);
    chk("R8 flush suppresses bubble", int'(bubble_dx), 0);
    chk("R8 flush_fd", int'(flush_fd), 1);
    chk("R8 flush_dx", int'(flush_dx), 1);

    // Stub pipeline run (R9 and per-cycle comparison)
    for (int i = 0; i < 12; i++) prog[i] = mk(NOP, 0, 0, 0, i);
    prog[0] = mk(LOAD, 3, 5, 0, 0);
    prog[1] = mk(ALU, 4, 3, 2, 1);
    prog[2] = mk(STORE, 0, 7, 4, 2);
    prog[3] = mk(LOAD, 6, 1, 0, 3);
    prog[4] = mk(STORE, 0, 2, 6, 4);
    prog[5] = mk(BRANCH, 0, 6, 0, 5); prog[5].tk = 1'b1; prog[5].tgt = 8;
    prog[6] = mk(ALU, 9, 1, 1, 6);
    prog[7] = mk(ALU, 10, 1, 1, 7);
    prog[8] = mk(ALU, 11, 6, 0, 8);
    clear_all();
    pc = 0; bubbles = 0; wrong_path = 0;
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(posedge clk);
      h = want_hz();
      bt = br_in;
      mw_l = xm_l;
      xm_l = dx_l;
      if (bt || h) dx_l = bubble(); else dx_l = fd_l;
      if (bt) begin
        fd_l = bubble();
        pc = xm_l.tgt;
      end else if (!h) begin
        fd_l = (pc < 12) ? prog[pc] : bubble();
        pc++;
      end
      if (h) bubbles++;
      br_in = dx_l.v && dx_l.op == BRANCH && dx_l.tk;
      if (xm_l.v && (xm_l.id == 6 || xm_l.id == 7)) wrong_path++;
      @(negedge clk);
      compare_all();
      if (dx_l.v && dx_l.id == 1) chk("R9 consumer uses WX path", int'(alu_a_sel), 1);
      if (xm_l.v && xm_l.id == 4) chk("R9 store after load gets WM data", int'(st_data_sel), 1);
    end
    chk("R9 one bubble for load-use", bubbles, 1);
    chk("R9 wrong path never in X/M", wrong_path, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule